// File: doc/BRIEF.md
# Tape and Keyboard Control Register Block

This block gives an auxiliary processor a small page of control and status registers, decoded in a 256-offset byte window. Writes to single-bit addresses build up a 3-bit tape transport mode and a 4-bit keyboard scan column, one bit at a time from data bit 0. Other write addresses hold a tape interrupt enable, a text blanking flag and six spare one-bit latches. Reads return raw tape sense lines shifted to bit 7, the keyboard row byte for the current scan column, and the state of two interrupt-pending flags.

Two pending flags, one for the tape and one for a serial source, are set by strobes from outside. Either a read or a write to each flag's own clear address clears it. The block drives an interrupt request from these flags. A 16-offset page is passed straight through to a display timing controller on a narrow sub-port. The block does not decode that page itself.

Read data is registered and appears in the cycle after the read strobe. Every other output comes directly from a register or from the bus inputs.

Top module: `tkc_ctrl_regs`

## Requirements
- R1: After reset, motor_mode, kbd_col, misc_latch and bus_rdata are zero, text_blank is 1, irq is 0, and both pending flags are clear.
- R2: A write puts bus_wdata[0] into one motor_mode bit: offset 0x20 loads bit 2, offset 0x21 loads bit 1 and offset 0x22 loads bit 0. The other two bits keep their values.
- R3: motor_state is one-hot. Bit 0 means idle (mode 0 to 3), bit 1 eject (mode 4), bit 2 play/record (mode 5), bit 3 rewind (mode 6) and bit 4 fast forward (mode 7).
- R4: A write to offset 0x44+k, for k from 0 to 3, loads bus_wdata[0] into kbd_col[k]. The other column bits keep their values.
- R5: A read at 0x60 returns kbd_rows[8c+7:8c] when the column c is 0 to 9. For any other column it returns 0xFF.
- R6: A read at offset n, for n from 0 to 5, returns tape_sense[7-n] in bit 7 with all other bits zero.
- R7: A read at 0x06 returns 0x00 while the serial pending flag is set and 0x80 while it is clear. Offset 0x07 reports the tape pending flag in the same way.
- R8: A read or a write at 0x80 clears the tape pending flag, and a read or a write at 0xA0 clears the serial pending flag. Reads at these two offsets return 0x00. A set strobe in the same cycle wins over the clear.
- R9: Writing bus_wdata[0]=1 to 0x43 clears text_blank, and writing 0 sets it. bus_wdata[0] written to 0x41 becomes the tape interrupt enable.
- R10: bus_wdata[0] written to offsets 0x23 to 0x27 loads misc_latch[0] to misc_latch[4] in that order. A write to 0x40 loads misc_latch[5].
- R11: irq is 1 exactly when the serial flag is pending, or when the tape flag is pending and the tape interrupt enable is set.
- R12: For offsets 0xC0 to 0xCF, in the same cycle, crt_sel is 1, crt_wr follows bus_wr, crt_addr is bus_addr[3:0] and crt_wdata is bus_wdata. A read in that page returns crt_rdata one cycle later.
- R13: bus_rdata is 0x00 in the cycle after any cycle without a read, and after a read of an offset not listed above. Writes to read-only offsets change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tape_sense | input | 8 | Raw tape sense lines |
| kbd_rows | input | 80 | Ten row bytes; column c at bits 8c+7:8c |
| set_tape_pend | input | 1 | Sets the tape pending flag |
| set_sr1_pend | input | 1 | Sets the serial pending flag |
| motor_mode | output | 3 | Tape transport mode code |
| motor_state | output | 5 | One-hot decoded transport state |
| kbd_col | output | 4 | Keyboard scan column |
| text_blank | output | 1 | Text blanking flag |
| misc_latch | output | 6 | Spare one-bit latches |
| irq | output | 1 | Interrupt request |
| crt_sel | output | 1 | Display controller page access |
| crt_wr | output | 1 | Display controller write |
| crt_addr | output | 4 | Display controller register index |
| crt_wdata | output | 8 | Display controller write data |
| crt_rdata | input | 8 | Display controller read data |

## Verification
Latch, mode, column, flag and irq results take effect on the clock edge that samples the write, clear or set strobe. Read data comes out on the edge after the read. The sub-port outputs follow the bus inputs in the same cycle, with no register. The bench drives each stimulus just after a rising edge and updates its reference model on the next rising edge. It compares every output at the falling edge that follows, so each registered result is checked one edge after its cause and each pass-through value is checked within its own cycle. In the cycles where a set strobe and a clear access coincide, the model confirms that the flag stays pending while the returned byte reflects the flag's value from before that edge.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int MODE_W  = 3;
    localparam int COL_W   = 4;
    localparam int MISC_N  = 6;
    localparam int SENSE_N = 6;
    localparam int CRT_AW  = 4;
    localparam int STATE_N = (1 << (MODE_W - 1)) + 1;

    localparam logic [AW-1:0] A_SENSE0   = 8'h00;
    localparam logic [AW-1:0] A_SR1_ST   = 8'h06;
    localparam logic [AW-1:0] A_TAPE_ST  = 8'h07;
    localparam logic [AW-1:0] A_MODE_HI  = 8'h20;
    localparam logic [AW-1:0] A_MISC_LO  = 8'h23;
    localparam logic [AW-1:0] A_MISC_HI  = 8'h40;
    localparam logic [AW-1:0] A_IRQ_EN   = 8'h41;
    localparam logic [AW-1:0] A_BLANK    = 8'h43;
    localparam logic [AW-1:0] A_COL0     = 8'h44;
    localparam logic [AW-1:0] A_KBD      = 8'h60;
    localparam logic [AW-1:0] A_CLR_TAPE = 8'h80;
    localparam logic [AW-1:0] A_CLR_SR1  = 8'hA0;
    localparam logic [AW-CRT_AW-1:0] CRT_PAGE = 4'hC;

    // Per-cycle strobes from the address decoder
    typedef struct packed {
        logic [MODE_W-1:0]  wr_mode;
        logic [COL_W-1:0]   wr_col;
        logic [MISC_N-1:0]  wr_misc;
        logic               wr_irq_en;
        logic               wr_blank;
        logic [SENSE_N-1:0] rd_sense;
        logic               rd_sr1_st;
        logic               rd_tape_st;
        logic               rd_kbd;
        logic               clr_tape;
        logic               clr_sr1;
        logic               crt_hit;
    } tkc_hit_t;

    // Architectural state of the register block
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [COL_W-1:0]  col;
        logic              irq_en;
        logic              blank;
        logic [MISC_N-1:0] misc;
        logic              tape_pend;
        logic              sr1_pend;
        logic [DW-1:0]     rdata;
    } tkc_state_t;

    localparam tkc_state_t ST_RESET = '{
        mode: '0, col: '0, irq_en: 1'b0, blank: 1'b1,
        misc: '0, tape_pend: 1'b0, sr1_pend: 1'b0, rdata: '0
    };
endpackage

// File: rtl/tkc_addr_dec.sv
module tkc_addr_dec
    import tkc_pkg::*;
(
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output tkc_hit_t      hit
);
    logic access;
    assign access = bus_rd | bus_wr;

    always_comb begin
        hit = '0;
        // mode bits are assigned from the high bit down, one offset each
        for (int b = 0; b < MODE_W; b++)
            hit.wr_mode[b] = bus_wr && (bus_addr == A_MODE_HI + AW'(MODE_W - 1 - b));
        for (int b = 0; b < COL_W; b++)
            hit.wr_col[b] = bus_wr && (bus_addr == A_COL0 + AW'(b));
        for (int i = 0; i < MISC_N - 1; i++)
            hit.wr_misc[i] = bus_wr && (bus_addr == A_MISC_LO + AW'(i));
        hit.wr_misc[MISC_N-1] = bus_wr && (bus_addr == A_MISC_HI);
        hit.wr_irq_en = bus_wr && (bus_addr == A_IRQ_EN);
        hit.wr_blank  = bus_wr && (bus_addr == A_BLANK);
        for (int i = 0; i < SENSE_N; i++)
            hit.rd_sense[i] = bus_rd && (bus_addr == A_SENSE0 + AW'(i));
        hit.rd_sr1_st  = bus_rd && (bus_addr == A_SR1_ST);
        hit.rd_tape_st = bus_rd && (bus_addr == A_TAPE_ST);
        hit.rd_kbd     = bus_rd && (bus_addr == A_KBD);
        hit.clr_tape   = access && (bus_addr == A_CLR_TAPE);
        hit.clr_sr1    = access && (bus_addr == A_CLR_SR1);
        hit.crt_hit    = access && (bus_addr[AW-1:CRT_AW] == CRT_PAGE);
    end
endmodule

// File: rtl/tkc_row_mux.sv
module tkc_row_mux #(
    parameter int NUM_COLS = 10,
    parameter int COL_W    = 4,
    parameter int DW       = 8
) (
    input  logic [COL_W-1:0]       col,
    input  logic [NUM_COLS*DW-1:0] rows,
    output logic [DW-1:0]          row
);
    // An unpopulated column reads as all ones (no key pressed)
    always_comb begin
        row = '1;
        for (int c = 0; c < NUM_COLS; c++)
            if (col == COL_W'(c)) row = rows[c*DW +: DW];
    end
endmodule

// File: rtl/tkc_mode_dec.sv
module tkc_mode_dec #(
    parameter int MODE_W = 3,
    localparam int HALF    = 1 << (MODE_W - 1),
    localparam int STATE_N = HALF + 1
) (
    input  logic [MODE_W-1:0]  mode,
    output logic [STATE_N-1:0] state
);
    // Top mode bit clear: all codes collapse to idle
    assign state[0] = ~mode[MODE_W-1];

    for (genvar k = 0; k < HALF; k++) begin : g_active
        assign state[k+1] = mode[MODE_W-1] && (mode[MODE_W-2:0] == (MODE_W-1)'(k));
    end
endmodule

// File: rtl/tkc_ctrl_regs.sv
module tkc_ctrl_regs
    import tkc_pkg::*;
#(
    parameter int NUM_COLS = 10,
    localparam int ROWS_W  = NUM_COLS * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [DW-1:0]      tape_sense,
    input  logic [ROWS_W-1:0]  kbd_rows,
    input  logic               set_tape_pend,
    input  logic               set_sr1_pend,
    output logic [MODE_W-1:0]  motor_mode,
    output logic [STATE_N-1:0] motor_state,
    output logic [COL_W-1:0]   kbd_col,
    output logic               text_blank,
    output logic [MISC_N-1:0]  misc_latch,
    output logic               irq,
    output logic               crt_sel,
    output logic               crt_wr,
    output logic [CRT_AW-1:0]  crt_addr,
    output logic [DW-1:0]      crt_wdata,
    input  logic [DW-1:0]      crt_rdata
);
    tkc_hit_t   hit;
    tkc_state_t st_d, st_q;
    logic [DW-1:0] row_byte;

    tkc_addr_dec u_dec (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    tkc_row_mux #(.NUM_COLS(NUM_COLS), .COL_W(COL_W), .DW(DW)) u_rows (
        .col  (st_q.col),
        .rows (kbd_rows),
        .row  (row_byte)
    );

    tkc_mode_dec #(.MODE_W(MODE_W)) u_mode (
        .mode  (st_q.mode),
        .state (motor_state)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        for (int b = 0; b < MODE_W; b++)
            if (hit.wr_mode[b]) st_d.mode[b] = bus_wdata[0];
        for (int b = 0; b < COL_W; b++)
            if (hit.wr_col[b]) st_d.col[b] = bus_wdata[0];
        for (int i = 0; i < MISC_N; i++)
            if (hit.wr_misc[i]) st_d.misc[i] = bus_wdata[0];
        if (hit.wr_irq_en) st_d.irq_en = bus_wdata[0];
        if (hit.wr_blank)  st_d.blank  = ~bus_wdata[0];

        // set strobe outranks a clearing access in the same cycle
        st_d.tape_pend = set_tape_pend | (st_q.tape_pend & ~hit.clr_tape);
        st_d.sr1_pend  = set_sr1_pend  | (st_q.sr1_pend  & ~hit.clr_sr1);

        if (bus_rd) begin
            for (int i = 0; i < SENSE_N; i++)
                if (hit.rd_sense[i])
                    st_d.rdata = {tape_sense[DW-1-i], {(DW-1){1'b0}}};
            if (hit.rd_sr1_st)  st_d.rdata = {~st_q.sr1_pend,  {(DW-1){1'b0}}};
            if (hit.rd_tape_st) st_d.rdata = {~st_q.tape_pend, {(DW-1){1'b0}}};
            if (hit.rd_kbd)     st_d.rdata = row_byte;
            if (hit.crt_hit)    st_d.rdata = crt_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RESET;
        else     st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign motor_mode = st_q.mode;
    assign kbd_col    = st_q.col;
    assign text_blank = st_q.blank;
    assign misc_latch = st_q.misc;
    assign irq        = (st_q.tape_pend & st_q.irq_en) | st_q.sr1_pend;

    assign crt_sel   = hit.crt_hit;
    assign crt_wr    = hit.crt_hit & bus_wr;
    assign crt_addr  = bus_addr[CRT_AW-1:0];
    assign crt_wdata = bus_wdata;
endmodule

// File: rtl/tkc_ctrl_regs_chk.sv
module tkc_ctrl_regs_chk
    import tkc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [AW-1:0]      bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic [DW-1:0]      bus_rdata,
    input logic               set_sr1_pend,
    input logic               sr1_pend,
    input logic [MODE_W-1:0]  motor_mode,
    input logic [STATE_N-1:0] motor_state,
    input logic [COL_W-1:0]   kbd_col,
    input logic               irq,
    input logic               crt_sel,
    input logic [CRT_AW-1:0]  crt_addr
);
    p_state_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(motor_state) == 1);

    p_mode_hi_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MODE_HI) |=>
            (motor_mode[MODE_W-1] == $past(bus_wdata[0])) &&
            (motor_mode[MODE_W-2:0] == $past(motor_mode[MODE_W-2:0])));

    p_col_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(kbd_col));

    p_sr1_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_sr1_pend |=> sr1_pend);

    p_sr1_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr == A_CLR_SR1 && !set_sr1_pend) |=> !sr1_pend);

    p_sr1_raises_irq_r11: assert property (@(posedge clk) disable iff (rst)
        sr1_pend |-> irq);

    p_crt_index_r12: assert property (@(posedge clk) disable iff (rst)
        crt_sel |-> (crt_addr == bus_addr[CRT_AW-1:0]));

    p_rdata_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind tkc_ctrl_regs tkc_ctrl_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .set_sr1_pend (set_sr1_pend),
    .sr1_pend     (st_q.sr1_pend),
    .motor_mode   (motor_mode),
    .motor_state  (motor_state),
    .kbd_col      (kbd_col),
    .irq          (irq),
    .crt_sel      (crt_sel),
    .crt_addr     (crt_addr)
);

// File: tb/tkc_ctrl_regs_bench.sv
module tkc_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0, bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic [7:0]  tape_sense = 0;
    logic [79:0] kbd_rows = 0;
    logic        set_tape_pend = 0, set_sr1_pend = 0;
    logic [2:0]  motor_mode;
    logic [4:0]  motor_state;
    logic [3:0]  kbd_col;
    logic        text_blank, irq, crt_sel, crt_wr;
    logic [5:0]  misc_latch;
    logic [3:0]  crt_addr;
    logic [7:0]  crt_wdata, crt_rdata;

    int total = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign crt_rdata = {~crt_addr, crt_addr};

    tkc_ctrl_regs u_tkc_ctrl_regs (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tape_sense(tape_sense), .kbd_rows(kbd_rows),
        .set_tape_pend(set_tape_pend), .set_sr1_pend(set_sr1_pend),
        .motor_mode(motor_mode), .motor_state(motor_state), .kbd_col(kbd_col),
        .text_blank(text_blank), .misc_latch(misc_latch), .irq(irq),
        .crt_sel(crt_sel), .crt_wr(crt_wr), .crt_addr(crt_addr),
        .crt_wdata(crt_wdata), .crt_rdata(crt_rdata)
    );

    // Behavioural reference model
    logic [2:0] m_mode;
    logic [3:0] m_col;
    logic       m_en, m_blank, m_tp, m_sp;
    logic [5:0] m_misc;
    logic [7:0] m_rdata;
    string      m_rtag;

    always @(posedge clk) begin : model
        logic [7:0] rv;
        string tg;
        bit acc, d;
        if (rst) begin
            m_mode = 0; m_col = 0; m_en = 0; m_blank = 1; m_misc = 0;
            m_tp = 0; m_sp = 0; m_rdata = 0; m_rtag = "R1";
        end else begin
            rv = 8'h00; tg = "R13";
            if (bus_rd) begin
                if (bus_addr <= 8'd5) begin
                    rv = tape_sense[7 - int'(bus_addr)] ? 8'h80 : 8'h00; tg = "R6";
                end else if (bus_addr == 8'h06) begin
                    rv = m_sp ? 8'h00 : 8'h80; tg = "R7";
                end else if (bus_addr == 8'h07) begin
                    rv = m_tp ? 8'h00 : 8'h80; tg = "R7";
                end else if (bus_addr == 8'h60) begin
                    rv = (m_col <= 4'd9) ? kbd_rows[int'(m_col)*8 +: 8] : 8'hFF; tg = "R5";
                end else if (bus_addr == 8'h80 || bus_addr == 8'hA0) begin
                    rv = 8'h00; tg = "R8";
                end else if (bus_addr[7:4] == 4'hC) begin
                    rv = {~bus_addr[3:0], bus_addr[3:0]}; tg = "R12";
                end
            end
            acc = bus_rd || bus_wr;
            m_tp = set_tape_pend || (m_tp && !(acc && bus_addr == 8'h80));
            m_sp = set_sr1_pend  || (m_sp && !(acc && bus_addr == 8'hA0));
            d = bus_wdata[0];
            if (bus_wr) begin
                case (bus_addr)
                    8'h20: m_mode[2] = d;
                    8'h21: m_mode[1] = d;
                    8'h22: m_mode[0] = d;
                    8'h23, 8'h24, 8'h25, 8'h26, 8'h27: m_misc[int'(bus_addr) - 'h23] = d;
                    8'h40: m_misc[5] = d;
                    8'h41: m_en = d;
                    8'h43: m_blank = !d;
                    8'h44: m_col[0] = d;
                    8'h45: m_col[1] = d;
                    8'h46: m_col[2] = d;
                    8'h47: m_col[3] = d;
                    default: ;
                endcase
            end
            m_rdata = rv; m_rtag = tg;
        end
    end

    task automatic chk(string tag, logic [79:0] act, logic [79:0] exp, string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin : compare
        logic [4:0] ms;
        bit crt_page;
        if (!done) begin
            ms = (m_mode < 3'd4) ? 5'b00001 : (5'b00010 << (m_mode - 3'd4));
            crt_page = (bus_rd || bus_wr) && bus_addr[7:4] == 4'hC;
            chk(rst ? "R1" : m_rtag, 80'(bus_rdata), 80'(m_rdata), "bus_rdata");
            chk(rst ? "R1" : "R2", 80'(motor_mode), 80'(m_mode), "motor_mode");
            chk(rst ? "R1" : "R3", 80'(motor_state), 80'(ms), "motor_state");
            chk(rst ? "R1" : "R4", 80'(kbd_col), 80'(m_col), "kbd_col");
            chk(rst ? "R1" : "R9", 80'(text_blank), 80'(m_blank), "text_blank");
            chk(rst ? "R1" : "R10", 80'(misc_latch), 80'(m_misc), "misc_latch");
            chk(rst ? "R1" : "R11", 80'(irq), 80'((m_tp && m_en) || m_sp), "irq");
            if (!rst) begin
                chk("R12", 80'(crt_sel), 80'(crt_page), "crt_sel");
                chk("R12", 80'(crt_wr), 80'(crt_page && bus_wr), "crt_wr");
                if (crt_page) begin
                    chk("R12", 80'(crt_addr), 80'(bus_addr[3:0]), "crt_addr");
                    chk("R12", 80'(crt_wdata), 80'(bus_wdata), "crt_wdata");
                end
            end
        end
    end

    task automatic cyc(bit r, bit w, logic [7:0] a, logic [7:0] dat,
                       bit st = 0, bit ss = 0);
        @(posedge clk); #2;
        bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = dat;
        set_tape_pend = st; set_sr1_pend = ss;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] dat); cyc(0, 1, a, dat); endtask
    task automatic rd(logic [7:0] a); cyc(1, 0, a, 8'h00); endtask
    task automatic idle(); cyc(0, 0, 8'h00, 8'h00); endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        kbd_rows = 80'h5A_A5_3C_C3_0F_F0_96_69_12_E7;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        idle();
        // R2/R3: mode bits one per address, including all-ones data
        wr(8'h20, 8'h01); wr(8'h22, 8'h01); wr(8'h21, 8'h01);
        wr(8'h22, 8'hFE); wr(8'h21, 8'h00); wr(8'h20, 8'hFE);
        wr(8'h21, 8'h01); wr(8'h22, 8'h01); wr(8'h20, 8'h01); idle();
        // R4/R5: every column, inside and outside 0-9
        for (int c = 0; c < 16; c++) begin
            for (int b = 0; b < 4; b++) wr(8'h44 + 8'(b), {7'h7F, 1'(c >> b)});
            rd(8'h60);
        end
        // R6: sense lines with two patterns
        tape_sense = 8'b1010_1100;
        for (int n = 0; n < 6; n++) rd(8'(n));
        tape_sense = 8'b0101_0011;
        for (int n = 0; n < 6; n++) rd(8'(n));
        // R7/R8/R11: pending flags
        rd(8'h06); rd(8'h07);
        cyc(0, 0, 8'h00, 8'h00, 1, 0); rd(8'h07);
        wr(8'h41, 8'h01); idle();
        rd(8'h80); rd(8'h07);
        cyc(0, 0, 8'h00, 8'h00, 0, 1); rd(8'h06);
        wr(8'hA0, 8'h00); rd(8'h06);
        cyc(0, 1, 8'h80, 8'h00, 1, 0); rd(8'h07);
        cyc(1, 0, 8'hA0, 8'h00, 0, 1); rd(8'h06);
        wr(8'h41, 8'h00); idle(); rd(8'hA0); wr(8'h80, 8'h55); idle();
        // R9: text blank
        wr(8'h43, 8'h01); idle(); wr(8'h43, 8'hFE); idle();
        // R10: spare latches
        for (int i = 0; i < 5; i++) wr(8'h23 + 8'(i), 8'h01);
        wr(8'h40, 8'h01); wr(8'h25, 8'h00); wr(8'h40, 8'h00); idle();
        // R12: display controller page
        wr(8'hC5, 8'h3C); rd(8'hCA); rd(8'hCF); rd(8'hD0); wr(8'hBF, 8'h11);
        // R13: unlisted offsets, writes to read-only offsets
        rd(8'h10); rd(8'h61); rd(8'h20); wr(8'h60, 8'h00); wr(8'h06, 8'h01);
        rd(8'h60); idle(); idle();
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule